// File: doc/BRIEF.md
# Key-Gated Serial Register Port

This block sits beside a byte-wide memory on a bus of chip-select, read and write strobes. Bus cycles arrive as one-clock read and write pulses from an upstream edge detector, together with a select flag and the eight data lines. Normally every cycle is left to the memory. Software can reach a hidden bank of eight 8-bit timekeeping registers through this block. It first issues a read to arm the block. It then writes a fixed 64-bit key, one bit per write cycle on data line 0. The key is the bytes C5, 3A, A3, 5C, C5, 3A, A3, 5C, and each byte is sent from its least-significant bit upward.

Once the whole key has matched, the next 64 selected cycles belong to the register bank and the memory is blocked. Each write cycle loads one bit from data line 0. Each read cycle drives one bit out on data line 0 alone. The bits are walked from bit 0 of register 0 to bit 7 of register 7. Written bits reach a register only when its full group of eight has been stepped through. An active-low abort input ends a transfer early unless a control bit in the bank tells the block to ignore that input.

Top module: `keyed_serial_regs`

## Requirements
- R1: After reset, mem_en is 1 and dq_oe is 0. The block waits for a read before it starts matching. The bank holds 8'h30 in register 4 and 0 in every other register, so the abort-ignore flag (register 4, bit 4) starts at 1.
- R2: A selected read followed by 64 selected writes opens a transfer when the writes carry the key on dq_in[0] in order. Key bit i is bit (i mod 8) of byte (i div 8) of C5, 3A, A3, 5C, C5, 3A, A3, 5C. mem_en stays 1 through the arming read and all 64 key writes.
- R3: A selected read outside a transfer moves the match pointer back to key bit 0 and starts a new attempt, including when it arrives partway through an attempt.
- R4: A key write whose bit differs from the expected key bit stalls the attempt. Every later write is ignored until a read arrives, even if the later writes carry the rest of the key.
- R5: During the 64 transfer cycles mem_en is 0. After the 64th cycle, mem_en returns to 1 and the block is idle. A new read is then needed before key writes count again.
- R6: A transfer read drives dq_oe = 8'h01 and drives dq_out[0] with the current bank bit. Cycle k of the transfer (k = 0..63) addresses bit k mod 8 of register k div 8. dq_oe is 0 in all other cycles.
- R7: A register changes only at the eighth cycle of its group, and only when the group contained at least one write. A group of pure reads leaves the register as it was.
- R8: When the abort-ignore flag is 0, a low on abort_n returns the block to idle with mem_en 1 and leaves every register unchanged, including a group that was partly written. When the flag is 1, abort_n has no effect.
- R9: Strobes that arrive while sel is 0 neither advance, break nor restart matching or transfer, and give dq_oe = 0.
- R10: A cycle with both strobes set is handled as a write. It neither restarts matching nor drives data out.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sel | input | 1 | Chip select for the current cycle, active high |
| rd_pulse | input | 1 | One-clock read-cycle strobe |
| wr_pulse | input | 1 | One-clock write-cycle strobe |
| dq_in | input | 8 | Data lines as driven by the bus master |
| abort_n | input | 1 | Active-low transfer abort |
| mem_en | output | 1 | 1 when the memory may serve the cycle |
| dq_out | output | 8 | Data driven toward the bus; only bit 0 carries data |
| dq_oe | output | 8 | Per-line output enable |

## Verification
The embedded properties check several rules on every clock. A read outside a transfer always resets the pointer. A stalled attempt holds its pointer until a read arrives. An effective abort always lands in idle. A transfer leaves after its last bit. Unselected or empty cycles never move the state. Registers change only at a group's eighth cycle. Output drive never overlaps memory access, and a simultaneous strobe pair never drives data.

Only the bench scenarios show the end-to-end effects. These are that the exact key order unlocks while a stalled attempt with the correct tail does not, that a restart mid-attempt really starts over, and that written bytes come back in the right bit order. They also show that an aborted partial group is discarded while earlier complete groups stay, and that the ignore flag keeps a transfer running through an abort.

// File: rtl/ksr_pkg.sv
package ksr_pkg;
    localparam int NREGS     = 8;
    localparam int REG_W     = 8;
    localparam int DATA_W    = 8;
    localparam int XFER_BITS = NREGS * REG_W;
    localparam int PTR_W     = $clog2(XFER_BITS);
    localparam int RIDX_W    = $clog2(NREGS);
    localparam int BIT_W     = $clog2(REG_W);

    // key bytes C5,3A,A3,5C twice, byte 0 in the low bits
    localparam logic [XFER_BITS-1:0] KEY = {2{32'h5CA33AC5}};

    localparam int            CTRL_REG = 4;
    localparam int            IGN_BIT  = 4;
    localparam logic [REG_W-1:0] CTRL_RST = 8'h30;

    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_HUNT = 2'd1,
        S_STALL = 2'd2,
        S_XFER = 2'd3
    } seq_state_t;

    typedef struct packed {
        logic rd;
        logic wr;
        logic bit0;
    } bus_ev_t;

    function automatic logic key_bit(input logic [PTR_W-1:0] idx);
        return KEY[idx];
    endfunction
endpackage

// File: rtl/ksr_sequencer.sv
module ksr_sequencer
    import ksr_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  bus_ev_t          ev,
    input  logic             abort_eff,
    output logic             xfer,
    output logic             step,
    output logic [PTR_W-1:0] ptr
);
    localparam logic [PTR_W-1:0] LAST = PTR_W'(XFER_BITS - 1);

    seq_state_t st;

    assign xfer = (st == S_XFER);
    assign step = xfer && (ev.rd || ev.wr) && !abort_eff;

    always_ff @(posedge clk) begin
        if (rst || abort_eff) begin
            st  <= S_IDLE;
            ptr <= '0;
        end else if (ev.wr) begin
            case (st)
                S_HUNT: begin
                    if (ev.bit0 == key_bit(ptr)) begin
                        ptr <= ptr + 1'b1;
                        if (ptr == LAST) st <= S_XFER;
                    end else begin
                        st <= S_STALL;
                    end
                end
                S_XFER: begin
                    ptr <= ptr + 1'b1;
                    if (ptr == LAST) st <= S_IDLE;
                end
                default: ;
            endcase
        end else if (ev.rd) begin
            if (st == S_XFER) begin
                ptr <= ptr + 1'b1;
                if (ptr == LAST) st <= S_IDLE;
            end else begin
                st  <= S_HUNT;
                ptr <= '0;
            end
        end
    end

    assert_read_restarts_R3: assert property (@(posedge clk) disable iff (rst)
        (ev.rd && !ev.wr && st != S_XFER && !abort_eff) |=> (st == S_HUNT && ptr == '0));

    assert_stall_holds_R4: assert property (@(posedge clk) disable iff (rst)
        (st == S_STALL && !(ev.rd && !ev.wr) && !abort_eff) |=> (st == S_STALL && $stable(ptr)));

    assert_abort_idle_R8: assert property (@(posedge clk) disable iff (rst)
        abort_eff |=> (st == S_IDLE && ptr == '0));

    assert_xfer_exit_R5: assert property (@(posedge clk) disable iff (rst)
        (step && ptr == LAST) |=> (st == S_IDLE));

    assert_quiet_cycle_R9: assert property (@(posedge clk) disable iff (rst)
        (!ev.rd && !ev.wr && !abort_eff) |=> ($stable(st) && $stable(ptr)));
endmodule

// File: rtl/ksr_regbank.sv
module ksr_regbank
    import ksr_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             step,
    input  logic             step_wr,
    input  logic             din,
    input  logic             abort_eff,
    input  logic [PTR_W-1:0] idx,
    output logic             cur_bit,
    output logic             ign_flag
);
    logic [NREGS-1:0][REG_W-1:0] regs;
    logic [REG_W-1:0]            shadow;
    logic [REG_W-1:0]            merged;
    logic                        dirty;
    logic [RIDX_W-1:0]           ri;
    logic [BIT_W-1:0]            bi;
    logic                        new_bit;
    logic                        group_end;

    assign ri        = idx[PTR_W-1:BIT_W];
    assign bi        = idx[BIT_W-1:0];
    assign cur_bit   = regs[ri][bi];
    assign ign_flag  = regs[CTRL_REG][IGN_BIT];
    assign new_bit   = step_wr ? din : cur_bit;
    assign group_end = (bi == BIT_W'(REG_W - 1));

    always_comb begin
        merged     = shadow;
        merged[bi] = new_bit;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int r = 0; r < NREGS; r++)
                regs[r] <= (r == CTRL_REG) ? CTRL_RST : '0;
            shadow <= '0;
            dirty  <= 1'b0;
        end else if (abort_eff) begin
            dirty <= 1'b0;
        end else if (step) begin
            shadow[bi] <= new_bit;
            if (group_end) begin
                dirty <= 1'b0;
                if (dirty || step_wr) regs[ri] <= merged;
            end else begin
                dirty <= (bi == '0) ? step_wr : (dirty || step_wr);
            end
        end
    end

    assert_commit_only_at_group_end_R7: assert property (@(posedge clk) disable iff (rst)
        (abort_eff || !step || !group_end) |=> $stable(regs));
endmodule

// File: rtl/keyed_serial_regs.sv
module keyed_serial_regs
    import ksr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              sel,
    input  logic              rd_pulse,
    input  logic              wr_pulse,
    input  logic [DATA_W-1:0] dq_in,
    input  logic              abort_n,
    output logic              mem_en,
    output logic [DATA_W-1:0] dq_out,
    output logic [DATA_W-1:0] dq_oe
);
    bus_ev_t          ev;
    logic             xfer;
    logic             step;
    logic [PTR_W-1:0] ptr;
    logic             cur_bit;
    logic             ign_flag;
    logic             abort_eff;

    assign ev.wr     = sel && wr_pulse;
    assign ev.rd     = sel && rd_pulse && !wr_pulse;
    assign ev.bit0   = dq_in[0];
    assign abort_eff = !abort_n && !ign_flag;

    ksr_sequencer u_seq (
        .clk       (clk),
        .rst       (rst),
        .ev        (ev),
        .abort_eff (abort_eff),
        .xfer      (xfer),
        .step      (step),
        .ptr       (ptr)
    );

    ksr_regbank u_bank (
        .clk       (clk),
        .rst       (rst),
        .step      (step),
        .step_wr   (ev.wr),
        .din       (dq_in[0]),
        .abort_eff (abort_eff),
        .idx       (ptr),
        .cur_bit   (cur_bit),
        .ign_flag  (ign_flag)
    );

    assign mem_en = !xfer;
    assign dq_out = {{(DATA_W-1){1'b0}}, cur_bit};
    assign dq_oe  = (xfer && ev.rd) ? DATA_W'(1) : '0;

    assert_drive_excludes_memory_R6: assert property (@(posedge clk) disable iff (rst)
        (dq_oe != '0) |-> !mem_en);

    assert_both_strobes_no_drive_R10: assert property (@(posedge clk) disable iff (rst)
        (sel && rd_pulse && wr_pulse) |-> (dq_oe == '0));
endmodule

// File: tb/keyed_serial_regs_bench.sv
`timescale 1ns/100ps
module keyed_serial_regs_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       sel = 1'b0, rd_pulse = 1'b0, wr_pulse = 1'b0, abort_n = 1'b1;
    logic [7:0] dq_in = '0;
    logic       mem_en;
    logic [7:0] dq_out, dq_oe;

    always #2.5 clk = ~clk;

    keyed_serial_regs u_keyed_serial_regs (
        .clk(clk), .rst(rst), .sel(sel), .rd_pulse(rd_pulse), .wr_pulse(wr_pulse),
        .dq_in(dq_in), .abort_n(abort_n), .mem_en(mem_en), .dq_out(dq_out), .dq_oe(dq_oe)
    );

    typedef struct {
        bit    mem;
        bit    oe;
        bit    b;
        string tag;
    } exp_t;

    exp_t q[$];
    event mon_ev;
    int   total = 0, bad = 0;
    bit   finished = 0;
    logic [7:0] exp_regs [8];
    logic [7:0] kb [4] = '{8'hC5, 8'h3A, 8'hA3, 8'h5C};

    function automatic bit keyb(int i);
        return kb[(i / 8) % 4][i % 8];
    endfunction

    // monitor: pops expectations and compares with the outputs
    initial begin
        forever begin
            @(mon_ev);
            while (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                total++;
                if (mem_en !== e.mem) begin
                    bad++;
                    $display("FAIL %s mem_en actual=%b expected=%b", e.tag, mem_en, e.mem);
                end else if (dq_oe !== (e.oe ? 8'h01 : 8'h00)) begin
                    bad++;
                    $display("FAIL %s dq_oe actual=%h expected=%h", e.tag, dq_oe, e.oe ? 8'h01 : 8'h00);
                end else if (e.oe && dq_out[0] !== e.b) begin
                    bad++;
                    $display("FAIL %s dq_out0 actual=%b expected=%b", e.tag, dq_out[0], e.b);
                end
            end
        end
    end

    task automatic cyc(input bit s, input bit r, input bit w, input logic [7:0] d,
                       input bit ab, input bit em, input bit eo, input bit eb, input string tag);
        exp_t e;
        @(negedge clk);
        sel = s; rd_pulse = r; wr_pulse = w; dq_in = d; abort_n = ab;
        #1;
        e.mem = em; e.oe = eo; e.b = eb; e.tag = tag;
        q.push_back(e);
        ->mon_ev;
    endtask

    task automatic idle(input bit em, input string tag);
        cyc(0, 0, 0, 8'h00, 1, em, 0, 0, tag);
    endtask

    task automatic unlock(input string tag);
        cyc(1, 1, 0, 8'h00, 1, 1, 0, 0, tag);
        for (int i = 0; i < 64; i++)
            cyc(1, 0, 1, {7'($urandom), keyb(i)}, 1, 1, 0, 0, tag);
    endtask

    task automatic read_all(input string tag);
        for (int i = 0; i < 64; i++)
            cyc(1, 1, 0, 8'h00, 1, 0, 1, exp_regs[i / 8][i % 8], tag);
    endtask

    task automatic write_all(input logic [7:0] v [8], input int both_reg, input string tag);
        for (int i = 0; i < 64; i++)
            cyc(1, (i / 8) == both_reg, 1, {7'h7F, v[i / 8][i % 8]}, 1, 0, 0, 0, tag);
        for (int r = 0; r < 8; r++) exp_regs[r] = v[r];
    endtask

    initial begin
        #(5.0 * 200000);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] v [8];
        for (int r = 0; r < 8; r++) exp_regs[r] = (r == 4) ? 8'h30 : 8'h00;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset state, defaults readable after unlock
        idle(1, "R1 reset");
        unlock("R2 key unlock");
        read_all("R1/R6 default bank readout");
        idle(1, "R5 memory restored");

        // R5: key writes without an arming read do not unlock
        for (int i = 0; i < 64; i++)
            cyc(1, 0, 1, {7'h00, keyb(i)}, 1, 1, 0, 0, "R5 unarmed writes");
        cyc(1, 1, 0, 8'h00, 1, 1, 0, 0, "R5 read still memory");

        // R7: write full bank; reg4 bit4 cleared
        v = '{8'h11, 8'h22, 8'h5A, 8'h96, 8'h25, 8'h81, 8'hC3, 8'h7E};
        unlock("R2 unlock for write");
        write_all(v, -1, "R7 bank write");
        idle(1, "R5 after write");

        // R4: mismatch stalls, correct tail ignored
        cyc(1, 1, 0, 8'h00, 1, 1, 0, 0, "R4 arm");
        for (int i = 0; i < 10; i++) cyc(1, 0, 1, {7'h00, keyb(i)}, 1, 1, 0, 0, "R4 good bits");
        cyc(1, 0, 1, {7'h00, ~keyb(10)}, 1, 1, 0, 0, "R4 bad bit");
        for (int i = 10; i < 64; i++) cyc(1, 0, 1, {7'h00, keyb(i)}, 1, 1, 0, 0, "R4 tail ignored");
        cyc(1, 1, 0, 8'h00, 1, 1, 0, 0, "R4 still locked");

        // R3: restart mid-attempt then full key; reads back written bank
        cyc(1, 1, 0, 8'h00, 1, 1, 0, 0, "R3 arm");
        for (int i = 0; i < 20; i++) cyc(1, 0, 1, {7'h00, keyb(i)}, 1, 1, 0, 0, "R3 partial");
        unlock("R3 restart unlock");
        read_all("R3/R7 readback");
        idle(1, "R5 after readback");

        // R9 and R10: interleaved unselected cycles, simultaneous strobes
        cyc(1, 1, 0, 8'h00, 1, 1, 0, 0, "R9 arm");
        for (int i = 0; i < 64; i++) begin
            cyc(0, 1, 0, 8'h00, 1, 1, 0, 0, "R9 unselected read");
            cyc(0, 0, 1, {7'h00, ~keyb(i)}, 1, 1, 0, 0, "R9 unselected write");
            cyc(1, i == 30, 1, {7'h00, keyb(i)}, 1, 1, 0, 0, "R9/R10 key write");
        end
        for (int i = 0; i < 64; i++) begin
            cyc(0, 1, 0, 8'h00, 1, 0, 0, 0, "R9 unselected in transfer");
            cyc(1, 1, 0, 8'h00, 1, 0, 1, exp_regs[i / 8][i % 8], "R9 interleaved readout");
        end
        idle(1, "R9 after transfer");

        // R10: both strobes in transfer act as writes
        v = '{8'h11, 8'h22, 8'hE7, 8'h96, 8'h25, 8'h81, 8'hC3, 8'h7E};
        unlock("R10 unlock");
        write_all(v, 2, "R10 both strobes write");
        unlock("R10 unlock check");
        read_all("R10 readback");

        // R8: abort with flag 0 discards partial group, keeps full group
        unlock("R8 unlock");
        for (int i = 0; i < 8; i++) cyc(1, 0, 1, {7'h00, 8'hAA >> i}, 1, 0, 0, 0, "R8 reg0 write");
        for (int i = 0; i < 5; i++) cyc(1, 0, 1, 8'h01, 1, 0, 0, 0, "R8 reg1 partial");
        cyc(0, 0, 0, 8'h00, 0, 0, 0, 0, "R8 abort cycle");
        idle(1, "R8 idle after abort");
        cyc(1, 0, 1, 8'h01, 1, 1, 0, 0, "R8 write after abort is memory");
        exp_regs[0] = 8'hAA;
        unlock("R8 unlock check");
        read_all("R8/R7 abort readback");

        // R8: flag set to 1, abort ignored
        v = exp_regs;
        v[4] = 8'h35;
        unlock("R8 unlock set flag");
        write_all(v, -1, "R8 flag write");
        unlock("R8 unlock ignore");
        for (int i = 0; i < 3; i++)
            cyc(1, 1, 0, 8'h00, 1, 0, 1, exp_regs[0][i], "R8 read before abort");
        cyc(0, 0, 0, 8'h00, 0, 0, 0, 0, "R8 abort ignored");
        for (int i = 3; i < 64; i++)
            cyc(1, 1, 0, 8'h00, 1, 0, 1, exp_regs[i / 8][i % 8], "R8 read after ignored abort");
        idle(1, "R5 final idle");

        @(negedge clk);
        #1;
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule